// File: doc/BRIEF.md
# Float to Signed Integer Converter

This block turns an unpacked floating-point operand into a 32-bit two's-complement integer. The operand arrives as a class code, a sign, a signed unbiased exponent and a normalised mantissa whose leading one is explicit at the top bit. The result is always truncated toward zero. There is no rounding-mode input.

The datapath lines up the mantissa so that its integer part lands in the low 32 bits. It notes whether any bits fell below the binary point. It then checks the truncated magnitude against the signed range and either negates it or saturates it. Any operand that does not fit is reported as invalid, as is every infinity and every NaN. For those operands the saturated value depends on the sign, and the inexact flag is suppressed.

One register stage holds the result. A result appears one cycle after a valid operand and stays put while no new operand is offered.

Top module: `f2i_trunc`

## Requirements
- R1: An operand of class 00 (zero) gives integer 0 with both flags low, whatever its sign, exponent and mantissa.
- R2: A number (class 01) whose value lies within range gives its integer part truncated toward zero; fractional bits never round the magnitude up.
- R3: A number with a signed exponent of 32 or more is out of range, whatever its mantissa.
- R4: The inexact flag rises when any mantissa bit weighted below 2^0 is non-zero. This includes every exponent below -1, where the integer result is 0.
- R5: The truncated magnitude is out of range when it is at least 2^31 plus the sign bit. So -2^31 converts to 0x80000000 without invalid, and +2^31 does not convert.
- R6: A negative in-range number gives the two's complement of its truncated magnitude.
- R7: Class 10 (infinity) and class 11 (NaN) always take the out-of-range path.
- R8: For an out-of-range operand, invalid is 1 and inexact is 0, even when bits below the binary point were non-zero.
- R9: The out-of-range result is 0x7FFFFFFF for sign 0 and 0x80000000 for sign 1.
- R10: The result, its flags and out_valid_o appear on the first clock edge after in_valid_i is sampled high. While in_valid_i is low, out_valid_o is 0 and the result and flags hold. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Operand present this cycle |
| in_class_i | input | 2 | 00 zero, 01 number, 10 infinity, 11 NaN |
| in_sign_i | input | 1 | 1 for a negative operand |
| in_exp_i | input | 12 | Signed unbiased exponent |
| in_mant_i | input | 40 | Normalised mantissa, bit 39 is the leading one, value mant·2^(exp-39) |
| out_valid_o | output | 1 | Result registered from a valid operand |
| out_int_o | output | 32 | Two's-complement integer result |
| out_inexact_o | output | 1 | Bits were discarded by truncation |
| out_invalid_o | output | 1 | Operand was out of range, infinite or NaN |

## Verification
The bench targets the edges of the signed range:
- -2^31 exactly, and -2^31 with a half below the binary point, must both give 0x80000000. A comparison that ignores the sign would wrongly flag them invalid.
- +2^31, and -(2^31+1), must saturate. A design that checks only the exponent would let them wrap.

Negative fractions such as -2.5 must give -2. A design that rounds, or one that negates before truncating, would give -3.

Three more cases are probed:
- Exponents of -1 and far below must give 0 with inexact. A shift-amount computation that wraps on negative exponents would produce garbage there.
- Out-of-range operands that carry fraction bits must report invalid only, not both flags.
- Zero-class operands that carry stray mantissa bits must still give 0 with no flags.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

    // operand class code carried with each unpacked value
    typedef enum logic [1:0] {
        CLS_ZERO = 2'b00,
        CLS_NUM  = 2'b01,
        CLS_INF  = 2'b10,
        CLS_NAN  = 2'b11
    } fcls_e;

    parameter int F2I_INT_W  = 32;
    parameter int F2I_EXP_W  = 12;
    parameter int F2I_MANT_W = 40;

endpackage

// File: rtl/f2i_align.sv
// Places the integer part of mant*2^(exp-(MANT_W-1)) into INT_W bits and
// reports whether anything non-zero sits below the binary point.
module f2i_align #(
    parameter int INT_W  = 32,
    parameter int EXP_W  = 12,
    parameter int MANT_W = 40
) (
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [MANT_W-1:0] mant_i,
    output logic [INT_W-1:0]  mag_o,
    output logic              lost_o,
    output logic              big_o
);
    localparam int W    = INT_W + MANT_W;
    localparam int SH_W = $clog2(INT_W + 1);
    localparam logic signed [EXP_W-1:0] EXP_LIM = EXP_W'(INT_W);
    localparam logic signed [EXP_W-1:0] EXP_M1  = '1;

    logic signed [EXP_W-1:0] exp_s;
    logic                    tiny;
    logic [SH_W-1:0]         shamt;
    logic [W-1:0]            wide;

    always_comb begin
        exp_s = $signed(exp_i);
        big_o = (exp_s >= EXP_LIM);
        tiny  = (exp_s < EXP_M1);
        // exp+1 is 0..INT_W on the useful range, so low bits suffice
        shamt = exp_i[SH_W-1:0] + SH_W'(1);
        wide  = {{INT_W{1'b0}}, mant_i} << shamt;
        if (tiny) begin
            mag_o  = '0;
            lost_o = |mant_i;
        end else begin
            mag_o  = wide[W-1:MANT_W];
            lost_o = |wide[MANT_W-1:0];
        end
    end
endmodule

// File: rtl/f2i_range.sv
// Decides whether the operand can be represented as a signed INT_W integer.
module f2i_range #(
    parameter int INT_W = 32
) (
    input  f2i_pkg::fcls_e   cls_i,
    input  logic             sign_i,
    input  logic             big_i,
    input  logic [INT_W-1:0] mag_i,
    output logic             ovf_o
);
    import f2i_pkg::*;

    logic [INT_W:0] limit;
    logic           mag_ovf;

    always_comb begin
        // 2^(INT_W-1) plus the sign: one extra code point on the negative side
        limit   = {2'b01, {(INT_W-1){1'b0}}} + (INT_W+1)'(sign_i);
        mag_ovf = ({1'b0, mag_i} >= limit);
        unique case (cls_i)
            CLS_ZERO: ovf_o = 1'b0;
            CLS_NUM:  ovf_o = big_i | mag_ovf;
            default:  ovf_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/f2i_pack.sv
// Forms the final integer and the two flags.
module f2i_pack #(
    parameter int INT_W = 32
) (
    input  f2i_pkg::fcls_e   cls_i,
    input  logic             sign_i,
    input  logic [INT_W-1:0] mag_i,
    input  logic             lost_i,
    input  logic             ovf_i,
    output logic [INT_W-1:0] val_o,
    output logic             inx_o,
    output logic             inv_o
);
    import f2i_pkg::*;

    logic [INT_W-1:0] sat;
    logic [INT_W-1:0] neg;

    always_comb begin
        sat = sign_i ? {1'b1, {(INT_W-1){1'b0}}} : {1'b0, {(INT_W-1){1'b1}}};
        neg = (~mag_i) + INT_W'(1);
        if (cls_i == CLS_ZERO) begin
            val_o = '0;
            inx_o = 1'b0;
            inv_o = 1'b0;
        end else if (ovf_i) begin
            val_o = sat;
            inx_o = 1'b0;
            inv_o = 1'b1;
        end else begin
            val_o = sign_i ? neg : mag_i;
            inx_o = lost_i;
            inv_o = 1'b0;
        end
    end
endmodule

// File: rtl/f2i_trunc.sv
module f2i_trunc #(
    parameter int INT_W  = f2i_pkg::F2I_INT_W,
    parameter int EXP_W  = f2i_pkg::F2I_EXP_W,
    parameter int MANT_W = f2i_pkg::F2I_MANT_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              in_valid_i,
    input  logic [1:0]        in_class_i,
    input  logic              in_sign_i,
    input  logic [EXP_W-1:0]  in_exp_i,
    input  logic [MANT_W-1:0] in_mant_i,
    output logic              out_valid_o,
    output logic [INT_W-1:0]  out_int_o,
    output logic              out_inexact_o,
    output logic              out_invalid_o
);
    import f2i_pkg::*;

    typedef struct packed {
        logic             vld;
        logic [INT_W-1:0] val;
        logic             inx;
        logic             inv;
    } res_t;

    fcls_e            cls;
    logic [INT_W-1:0] mag;
    logic             lost;
    logic             big;
    logic             ovf;
    logic [INT_W-1:0] val;
    logic             inx;
    logic             inv;
    res_t             res_d;
    res_t             res_q;

    assign cls = fcls_e'(in_class_i);

    f2i_align #(.INT_W(INT_W), .EXP_W(EXP_W), .MANT_W(MANT_W)) u_align (
        .exp_i  (in_exp_i),
        .mant_i (in_mant_i),
        .mag_o  (mag),
        .lost_o (lost),
        .big_o  (big)
    );

    f2i_range #(.INT_W(INT_W)) u_range (
        .cls_i  (cls),
        .sign_i (in_sign_i),
        .big_i  (big),
        .mag_i  (mag),
        .ovf_o  (ovf)
    );

    f2i_pack #(.INT_W(INT_W)) u_pack (
        .cls_i  (cls),
        .sign_i (in_sign_i),
        .mag_i  (mag),
        .lost_i (lost),
        .ovf_i  (ovf),
        .val_o  (val),
        .inx_o  (inx),
        .inv_o  (inv)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = in_valid_i;
        if (in_valid_i) begin
            res_d.val = val;
            res_d.inx = inx;
            res_d.inv = inv;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) res_q <= '0;
        else         res_q <= res_d;
    end

    assign out_valid_o   = res_q.vld;
    assign out_int_o     = res_q.val;
    assign out_inexact_o = res_q.inx;
    assign out_invalid_o = res_q.inv;
endmodule

// File: rtl/f2i_trunc_chk.sv
module f2i_trunc_chk #(
    parameter int INT_W  = 32,
    parameter int EXP_W  = 12,
    parameter int MANT_W = 40
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              in_valid_i,
    input logic [1:0]        in_class_i,
    input logic              in_sign_i,
    input logic [EXP_W-1:0]  in_exp_i,
    input logic [MANT_W-1:0] in_mant_i,
    input logic              out_valid_o,
    input logic [INT_W-1:0]  out_int_o,
    input logic              out_inexact_o,
    input logic              out_invalid_o
);
    localparam logic [INT_W-1:0] POS_SAT = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] NEG_SAT = {1'b1, {(INT_W-1){1'b0}}};
    localparam logic signed [EXP_W-1:0] EXP_LIM = EXP_W'(INT_W);

    assert_zero_class_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && in_class_i == 2'b00) |=>
            (out_int_o == '0 && !out_inexact_o && !out_invalid_o));

    assert_big_exp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && in_class_i == 2'b01 && $signed(in_exp_i) >= EXP_LIM) |=> out_invalid_o);

    assert_special_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && in_class_i[1]) |=> out_invalid_o);

    assert_flags_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_invalid_o |-> !out_inexact_o);

    assert_sat_value_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_invalid_o |-> (out_int_o == POS_SAT || out_int_o == NEG_SAT));

    assert_sat_sign_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && in_class_i[1]) |=> (out_int_o == ($past(in_sign_i) ? NEG_SAT : POS_SAT)));

    assert_valid_follow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> out_valid_o);

    assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!in_valid_i && out_valid_o) |=> (!out_valid_o && $stable(out_int_o)
                                          && $stable(out_invalid_o) && $stable(out_inexact_o)));
endmodule

bind f2i_trunc f2i_trunc_chk #(.INT_W(INT_W), .EXP_W(EXP_W), .MANT_W(MANT_W)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .in_valid_i    (in_valid_i),
    .in_class_i    (in_class_i),
    .in_sign_i     (in_sign_i),
    .in_exp_i      (in_exp_i),
    .in_mant_i     (in_mant_i),
    .out_valid_o   (out_valid_o),
    .out_int_o     (out_int_o),
    .out_inexact_o (out_inexact_o),
    .out_invalid_o (out_invalid_o)
);

// File: tb/sim_f2i_trunc.sv
module sim_f2i_trunc;
    localparam int NV = 22;

    typedef struct packed {
        logic [1:0]  cls;
        logic        sgn;
        logic [11:0] exp;
        logic [39:0] mant;
        logic [31:0] want;
        logic        inx;
        logic        inv;
    } vec_t;

    // value = mant * 2^(exp-39); exp is signed 12-bit
    localparam vec_t VEC [NV] = '{
        '{2'b00, 1'b0, 12'h000, 40'h0000000000, 32'h00000000, 1'b0, 1'b0}, // R1
        '{2'b00, 1'b1, 12'h01F, 40'h8000001234, 32'h00000000, 1'b0, 1'b0}, // R1 stray fields
        '{2'b01, 1'b0, 12'h000, 40'h8000000000, 32'h00000001, 1'b0, 1'b0}, // R2 1.0
        '{2'b01, 1'b0, 12'h001, 40'hA000000000, 32'h00000002, 1'b1, 1'b0}, // R2 2.5
        '{2'b01, 1'b1, 12'h001, 40'hA000000000, 32'hFFFFFFFE, 1'b1, 1'b0}, // R6 -2.5
        '{2'b01, 1'b0, 12'hFFF, 40'hC000000000, 32'h00000000, 1'b1, 1'b0}, // R4 0.75
        '{2'b01, 1'b1, 12'hFEC, 40'h8000000000, 32'h00000000, 1'b1, 1'b0}, // R4 -2^-20
        '{2'b01, 1'b0, 12'hF9C, 40'hFFFFFFFFFF, 32'h00000000, 1'b1, 1'b0}, // R4 exp -100
        '{2'b01, 1'b0, 12'h010, 40'hF120000000, 32'h0001E240, 1'b0, 1'b0}, // R2 123456
        '{2'b01, 1'b1, 12'h010, 40'hF120000000, 32'hFFFE1DC0, 1'b0, 1'b0}, // R6 -123456
        '{2'b01, 1'b0, 12'h01E, 40'hFFFFFFFE00, 32'h7FFFFFFF, 1'b0, 1'b0}, // R5 2^31-1
        '{2'b01, 1'b0, 12'h01F, 40'h8000000000, 32'h7FFFFFFF, 1'b0, 1'b1}, // R5 +2^31
        '{2'b01, 1'b1, 12'h01F, 40'h8000000000, 32'h80000000, 1'b0, 1'b0}, // R5 -2^31
        '{2'b01, 1'b1, 12'h01F, 40'h8000000080, 32'h80000000, 1'b1, 1'b0}, // R5 -(2^31+.5)
        '{2'b01, 1'b1, 12'h01F, 40'h8000000100, 32'h80000000, 1'b0, 1'b1}, // R9 -(2^31+1)
        '{2'b01, 1'b0, 12'h01F, 40'h8000000080, 32'h7FFFFFFF, 1'b0, 1'b1}, // R8 +(2^31+.5)
        '{2'b01, 1'b0, 12'h020, 40'h8000000000, 32'h7FFFFFFF, 1'b0, 1'b1}, // R3 exp 32
        '{2'b01, 1'b1, 12'h7FF, 40'hC000000000, 32'h80000000, 1'b0, 1'b1}, // R3 exp 2047
        '{2'b10, 1'b0, 12'h000, 40'h8000000000, 32'h7FFFFFFF, 1'b0, 1'b1}, // R7 +inf
        '{2'b11, 1'b1, 12'h000, 40'hC000000001, 32'h80000000, 1'b0, 1'b1}, // R7 NaN
        '{2'b10, 1'b1, 12'h000, 40'h0000000000, 32'h80000000, 1'b0, 1'b1}, // R9 -inf
        '{2'b11, 1'b0, 12'h000, 40'hFFFFFFFFFF, 32'h7FFFFFFF, 1'b0, 1'b1}  // R9 +NaN
    };

    string tag [NV];

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_class = '0;
    logic        in_sign = 1'b0;
    logic [11:0] in_exp = '0;
    logic [39:0] in_mant = '0;
    logic        out_valid;
    logic [31:0] out_int;
    logic        out_inx;
    logic        out_inv;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    f2i_trunc u0 (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .in_valid_i    (in_valid),
        .in_class_i    (in_class),
        .in_sign_i     (in_sign),
        .in_exp_i      (in_exp),
        .in_mant_i     (in_mant),
        .out_valid_o   (out_valid),
        .out_int_o     (out_int),
        .out_inexact_o (out_inx),
        .out_invalid_o (out_inv)
    );

    task automatic check(input string req, input logic vld, input logic [31:0] val,
                         input logic inx, input logic inv);
        checks++;
        if (out_valid !== vld || out_int !== val || out_inx !== inx || out_inv !== inv) begin
            errors++;
            $display("FAIL %s: got vld=%0b int=%h inx=%0b inv=%0b, want vld=%0b int=%h inx=%0b inv=%0b",
                     req, out_valid, out_int, out_inx, out_inv, vld, val, inx, inv);
        end
    endtask

    task automatic apply(input vec_t v, input string req);
        in_valid = 1'b1;
        in_class = v.cls;
        in_sign  = v.sgn;
        in_exp   = v.exp;
        in_mant  = v.mant;
        @(negedge clk);
        check(req, 1'b1, v.want, v.inx, v.inv);
    endtask

    initial begin
        tag = '{"R1", "R1", "R2", "R2", "R6", "R4", "R4", "R4", "R2", "R6", "R5",
                "R5", "R5", "R5", "R9", "R8", "R3", "R3", "R7", "R7", "R9", "R9"};
        // reset state, R10
        repeat (3) @(negedge clk);
        check("R10 reset", 1'b0, 32'h0, 1'b0, 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) apply(VEC[i], tag[i]);

        // no valid: outputs hold last result, valid drops (R10)
        in_valid = 1'b0;
        in_class = 2'b10;
        in_sign  = 1'b1;
        @(negedge clk);
        check("R10 hold", 1'b0, 32'h7FFFFFFF, 1'b0, 1'b1);
        @(negedge clk);
        check("R10 hold2", 1'b0, 32'h7FFFFFFF, 1'b0, 1'b1);

        // single-cycle latency after an idle gap, then a back-to-back pair (R10, R6)
        apply('{2'b01, 1'b1, 12'h000, 40'h8000000000, 32'hFFFFFFFF, 1'b0, 1'b0}, "R10 -1.0");
        apply('{2'b01, 1'b0, 12'h002, 40'hFFFFFFFFFF, 32'h00000007, 1'b1, 1'b0}, "R2 7.99");
        in_valid = 1'b0;

        // reset in mid-run clears outputs (R10)
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 rerst", 1'b0, 32'h0, 1'b0, 1'b0);
        rst_n = 1'b1;
        apply('{2'b00, 1'b0, 12'h7FF, 40'hFFFFFFFFFF, 32'h0, 1'b0, 1'b0}, "R1 after reset");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule